// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block is the control logic that decides which frequency setting drives a clock synthesizer. It watches three sources and always forwards the one with the highest priority. The sources are a recovery setting frozen at a watchdog timeout, a programmed divider pair (N, M), and a 5-bit gear code. The gear code comes either from strap pins sampled during reset or from a register select code, and an override bit picks between those two. The block forwards the active gear index, the active N/M pair and a mode code. It raises a one-cycle strobe whenever any of these change, so that the synthesizer can relock.

A programmed pair is taken on a write pulse, and only if it yields an output above the gear constant. That rule is (N+3)/(M+3) > 1, which is the same as N > M. An illegal pair is refused, and an error flag is raised instead. Once a watchdog timeout has been taken, every software-driven input is ignored. This lockout lasts until the watchdog enable is cleared.

Top module: `freq_src_sel`

## Requirements
- R1: While rst_n is low, the strap pins are captured every cycle. After reset they are held and shown on strap_o. Out of reset, mode_o is 0 (strap), gear_o equals the captured strap code, n_o and m_o are 0, and chg_o is 0.
- R2: When no accepted programmed pair is in force, override 0 gives mode_o = 0 with gear_o = strap code. Override 1 gives mode_o = 1 with gear_o = code_i. In both cases n_o and m_o are 0.
- R3: With prog_en_i high and an accepted pair held, mode_o = 2 and n_o/m_o show the held pair. gear_o follows code_i if the override is 1, else the strap code.
- R4: A pulse on nm_wr_i captures prog_n_i/prog_m_i only when prog_n_i > prog_m_i. Otherwise the held pair is kept and ratio_err_o goes to 1. The next accepted write clears ratio_err_o.
- R5: A pair written while prog_en_i is low is still captured. It takes effect as soon as prog_en_i is raised.
- R6: A pulse on wd_timeout_i with wd_en_i high enters recovery (mode_o = 3) and freezes a setting. If rcv_sel_i is 1 and rcv_n_i > rcv_m_i, the frozen setting is the recovery pair, with gear = override ? code_i : strap. Otherwise it is the strap code with N = M = 0.
- R7: In recovery, changes to override, code, prog_en, recovery inputs and further timeouts leave every output unchanged. Pair writes are discarded: the held pair and ratio_err_o stay as they were.
- R8: A low wd_en_i leaves recovery and restores the normal priority. A timeout that arrives while wd_en_i is low is ignored.
- R9: chg_o is high for exactly one cycle, in the cycle where any of mode_o, gear_o, n_o, m_o takes a new value. It stays low otherwise, including after a write that repeats the held pair. Every change is visible at the ports within two clock edges of its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| strap_i | input | 5 | Frequency-select strap pins |
| ovr_i | input | 1 | Override: 1 selects code_i instead of the strap code |
| code_i | input | 5 | Register-held gear select code |
| prog_en_i | input | 1 | Programmed-pair mode enable |
| nm_wr_i | input | 1 | One-cycle pulse: N/M register written |
| prog_n_i | input | 8 | Programmed N value |
| prog_m_i | input | 7 | Programmed M value |
| wd_en_i | input | 1 | Watchdog enable; low releases recovery |
| wd_timeout_i | input | 1 | One-cycle watchdog expiry pulse |
| rcv_sel_i | input | 1 | Recovery source: 0 strap code, 1 recovery pair |
| rcv_n_i | input | 8 | Recovery N value |
| rcv_m_i | input | 7 | Recovery M value |
| strap_o | output | 5 | Captured strap code, read-only |
| gear_o | output | 5 | Active gear/ratio index |
| n_o | output | 8 | Active N |
| m_o | output | 7 | Active M |
| mode_o | output | 2 | 0 strap, 1 code, 2 programmed, 3 recovery |
| chg_o | output | 1 | One-cycle frequency-change strobe |
| ratio_err_o | output | 1 | Last pair write was refused for a bad ratio |

## Verification
A wrong held pair or a wrong recovery state always surfaces as a wrong n_o, m_o or mode_o. This happens no later than two edges after the write or timeout that caused it, or else as soon as prog_en_i or wd_en_i exposes the hidden state. A broken change detector shows as a missing strobe, or an extra one, in the same cycle that the outputs move or fail to move. The bench therefore compares the settled outputs against a model after every action, and counts strobes inside a fixed window. A refused or discarded write is exposed by later enabling programmed mode and reading n_o and m_o.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    // Default widths shared by the block and its bench
    localparam int DEF_GEAR_W = 5;
    localparam int DEF_N_W    = 8;
    localparam int DEF_M_W    = 7;

    // Which source currently drives the synthesizer
    typedef enum logic [1:0] {
        SRC_STRAP = 2'd0,
        SRC_CODE  = 2'd1,
        SRC_PROG  = 2'd2,
        SRC_RCV   = 2'd3
    } src_e;
endpackage

// File: rtl/fsel_strap_latch.sv
// Strap capture: follows the strap pins while reset is low, then holds them.
// Assumes the straps are stable for at least one clock before reset release.
module fsel_strap_latch #(
    parameter int GEAR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GEAR_W-1:0] strap_i,
    output logic [GEAR_W-1:0] lat_o
);
    // Sample during reset, freeze afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) lat_o <= strap_i;
    end

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> $stable(lat_o)); // R1
endmodule

// File: rtl/fsel_pair_hold.sv
// Programmed N/M holder: takes a written pair only if N > M, i.e. (N+3)/(M+3) > 1.
// Otherwise it flags an error. Writes are dropped while lock_i is high.
// Assumes N_W >= M_W.
module fsel_pair_hold #(
    parameter int N_W = 8,
    parameter int M_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lock_i,
    input  logic           wr_i,
    input  logic [N_W-1:0] n_i,
    input  logic [M_W-1:0] m_i,
    output logic [N_W-1:0] n_o,
    output logic [M_W-1:0] m_o,
    output logic           valid_o,
    output logic           err_o
);
    logic legal;

    // Ratio legality of the incoming pair
    always_comb legal = n_i > N_W'(m_i);

    // Capture a legal pair, or record a refusal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_o     <= '0;
            m_o     <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else if (wr_i && !lock_i) begin
            if (legal) begin
                n_o     <= n_i;
                m_o     <= m_i;
                valid_o <= 1'b1;
                err_o   <= 1'b0;
            end else begin
                err_o   <= 1'b1;
            end
        end
    end

    AST_BAD_PAIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (wr_i && !lock_i && (n_i <= N_W'(m_i))) |=> ($stable(n_o) && $stable(m_o) && err_o)); // R4
    AST_HELD_LEGAL:    assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> (n_o > N_W'(m_o))); // R4
    AST_LOCK_N:        assert property (@(posedge clk) disable iff (!rst_n) (lock_i && wr_i) |=> $stable(n_o)); // R7
    AST_LOCK_ERR:      assert property (@(posedge clk) disable iff (!rst_n) (lock_i && wr_i) |=> $stable(err_o)); // R7
endmodule

// File: rtl/fsel_recovery.sv
// Recovery tracker: on a timeout with the watchdog enabled, it freezes the recovery setting
// and holds it until the enable drops. A bad recovery pair falls back to the strap code.
// Assumes N_W >= M_W.
module fsel_recovery #(
    parameter int GEAR_W = 5,
    parameter int N_W    = 8,
    parameter int M_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_en_i,
    input  logic              timeout_i,
    input  logic              sel_i,
    input  logic [N_W-1:0]    n_i,
    input  logic [M_W-1:0]    m_i,
    input  logic [GEAR_W-1:0] norm_gear_i,
    input  logic [GEAR_W-1:0] strap_i,
    output logic              active_o,
    output logic [GEAR_W-1:0] gear_o,
    output logic [N_W-1:0]    n_o,
    output logic [M_W-1:0]    m_o
);
    logic enter;
    logic use_pair;

    // Entry condition and choice of the frozen source
    always_comb begin
        enter    = timeout_i && wd_en_i && !active_o;
        use_pair = sel_i && (n_i > N_W'(m_i));
    end

    // Recovery state and its frozen setting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            gear_o   <= '0;
            n_o      <= '0;
            m_o      <= '0;
        end else if (!wd_en_i) begin
            active_o <= 1'b0;
        end else if (enter) begin
            active_o <= 1'b1;
            gear_o   <= use_pair ? norm_gear_i : strap_i;
            n_o      <= use_pair ? n_i : '0;
            m_o      <= use_pair ? m_i : '0;
        end
    end

    AST_RCV_ENTRY:  assert property (@(posedge clk) disable iff (!rst_n) (timeout_i && wd_en_i) |=> active_o); // R6
    AST_RCV_EXIT:   assert property (@(posedge clk) disable iff (!rst_n) !wd_en_i |=> !active_o); // R8
    AST_RCV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) active_o |=> (!active_o || ($stable(gear_o) && $stable(n_o) && $stable(m_o)))); // R7
endmodule

// File: rtl/fsel_out_stage.sv
// Output register with change detection: the new setting is registered, and a
// one-cycle strobe is raised in the same cycle whenever the setting differs.
// Assumes the settings feeding it are registered or derived from stable inputs.
module fsel_out_stage
    import fsel_pkg::*;
#(
    parameter int GEAR_W = 5,
    parameter int N_W    = 8,
    parameter int M_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GEAR_W-1:0] strap_i,
    input  src_e              mode_d,
    input  logic [GEAR_W-1:0] gear_d,
    input  logic [N_W-1:0]    n_d,
    input  logic [M_W-1:0]    m_d,
    output src_e              mode_o,
    output logic [GEAR_W-1:0] gear_o,
    output logic [N_W-1:0]    n_o,
    output logic [M_W-1:0]    m_o,
    output logic              chg_o
);
    logic differs;

    // Compare the candidate setting with the one in force
    always_comb differs = (mode_d != mode_o) || (gear_d != gear_o) || (n_d != n_o) || (m_d != m_o);

    // Register the setting and pulse on change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= SRC_STRAP;
            gear_o <= strap_i;
            n_o    <= '0;
            m_o    <= '0;
            chg_o  <= 1'b0;
        end else begin
            chg_o <= differs;
            if (differs) begin
                mode_o <= mode_d;
                gear_o <= gear_d;
                n_o    <= n_d;
                m_o    <= m_d;
            end
        end
    end

    AST_STROBE_REAL:  assert property (@(posedge clk) disable iff (!rst_n) chg_o |-> ((mode_o != $past(mode_o)) || (gear_o != $past(gear_o)) || (n_o != $past(n_o)) || (m_o != $past(m_o)))); // R9
    AST_NO_SILENT:    assert property (@(posedge clk) disable iff (!rst_n) ((mode_o != $past(mode_o)) || (gear_o != $past(gear_o)) || (n_o != $past(n_o)) || (m_o != $past(m_o))) |-> chg_o); // R9
    AST_PROG_RATIO:   assert property (@(posedge clk) disable iff (!rst_n) (mode_o == SRC_PROG) |-> (n_o > N_W'(m_o))); // R3
    AST_PLAIN_NO_NM:  assert property (@(posedge clk) disable iff (!rst_n) (mode_o == SRC_STRAP || mode_o == SRC_CODE) |-> (n_o == '0 && m_o == '0)); // R2
endmodule

// File: rtl/freq_src_sel.sv
// Top of the frequency source selector. Priority: recovery, then programmed pair, then
// override/strap code. The chosen setting is registered with a change strobe.
// Assumes nm_wr_i and wd_timeout_i are single-cycle pulses in the clk domain.
module freq_src_sel
    import fsel_pkg::*;
#(
    parameter int GEAR_W = DEF_GEAR_W,
    parameter int N_W    = DEF_N_W,
    parameter int M_W    = DEF_M_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GEAR_W-1:0] strap_i,
    input  logic              ovr_i,
    input  logic [GEAR_W-1:0] code_i,
    input  logic              prog_en_i,
    input  logic              nm_wr_i,
    input  logic [N_W-1:0]    prog_n_i,
    input  logic [M_W-1:0]    prog_m_i,
    input  logic              wd_en_i,
    input  logic              wd_timeout_i,
    input  logic              rcv_sel_i,
    input  logic [N_W-1:0]    rcv_n_i,
    input  logic [M_W-1:0]    rcv_m_i,
    output logic [GEAR_W-1:0] strap_o,
    output logic [GEAR_W-1:0] gear_o,
    output logic [N_W-1:0]    n_o,
    output logic [M_W-1:0]    m_o,
    output logic [1:0]        mode_o,
    output logic              chg_o,
    output logic              ratio_err_o
);
    logic [GEAR_W-1:0] lat;
    logic [GEAR_W-1:0] norm_gear;
    logic [N_W-1:0]    pn;
    logic [M_W-1:0]    pm;
    logic              pvalid;
    logic              rcv_act;
    logic [GEAR_W-1:0] rgear;
    logic [N_W-1:0]    rn;
    logic [M_W-1:0]    rm;
    src_e              mode_d;
    src_e              mode_q;
    logic [GEAR_W-1:0] gear_d;
    logic [N_W-1:0]    n_d;
    logic [M_W-1:0]    m_d;

    fsel_strap_latch #(.GEAR_W(GEAR_W)) strap_i0 (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .lat_o(lat)
    );

    fsel_pair_hold #(.N_W(N_W), .M_W(M_W)) pair_i0 (
        .clk(clk), .rst_n(rst_n), .lock_i(rcv_act), .wr_i(nm_wr_i),
        .n_i(prog_n_i), .m_i(prog_m_i), .n_o(pn), .m_o(pm),
        .valid_o(pvalid), .err_o(ratio_err_o)
    );

    // Gear code from the override choice
    always_comb norm_gear = ovr_i ? code_i : lat;

    fsel_recovery #(.GEAR_W(GEAR_W), .N_W(N_W), .M_W(M_W)) rcv_i0 (
        .clk(clk), .rst_n(rst_n), .wd_en_i(wd_en_i), .timeout_i(wd_timeout_i),
        .sel_i(rcv_sel_i), .n_i(rcv_n_i), .m_i(rcv_m_i),
        .norm_gear_i(norm_gear), .strap_i(lat), .active_o(rcv_act),
        .gear_o(rgear), .n_o(rn), .m_o(rm)
    );

    // Three-level priority choice of the candidate setting
    always_comb begin
        if (rcv_act) begin
            mode_d = SRC_RCV;
            gear_d = rgear;
            n_d    = rn;
            m_d    = rm;
        end else if (prog_en_i && pvalid) begin
            mode_d = SRC_PROG;
            gear_d = norm_gear;
            n_d    = pn;
            m_d    = pm;
        end else begin
            mode_d = ovr_i ? SRC_CODE : SRC_STRAP;
            gear_d = norm_gear;
            n_d    = '0;
            m_d    = '0;
        end
    end

    fsel_out_stage #(.GEAR_W(GEAR_W), .N_W(N_W), .M_W(M_W)) out_i0 (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .mode_d(mode_d), .gear_d(gear_d), .n_d(n_d), .m_d(m_d),
        .mode_o(mode_q), .gear_o(gear_o), .n_o(n_o), .m_o(m_o), .chg_o(chg_o)
    );

    // Plain-typed outputs
    always_comb begin
        mode_o  = mode_q;
        strap_o = lat;
    end

    AST_LOCK_MODE: assert property (@(posedge clk) disable iff (!rst_n) (rcv_act && $past(rcv_act)) |-> (mode_o == 2'd3)); // R7
endmodule

// File: tb/freq_src_sel_tb.sv
`timescale 1ns/1ps
module freq_src_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap = 5'b10110;
    logic       ovr = 0, pen = 0, wr = 0, wden = 0, to = 0, rsel = 0;
    logic [4:0] code = 0;
    logic [7:0] pn_in = 0, rn = 0;
    logic [6:0] pm_in = 0, rm = 0;
    logic [4:0] strap_o, gear_o;
    logic [7:0] n_o;
    logic [6:0] m_o;
    logic [1:0] mode_o;
    logic       chg_o, err_o;

    int total = 0, bad = 0;
    bit done = 0;

    // model state
    logic [4:0] m_lat;
    logic [7:0] m_pn = 0;
    logic [6:0] m_pm = 0;
    logic       m_pv = 0, m_err = 0, m_rcv = 0;
    logic [4:0] m_rgear = 0;
    logic [7:0] m_rn = 0;
    logic [6:0] m_rm = 0;

    always #5 clk = ~clk;

    freq_src_sel dut_i (
        .clk(clk), .rst_n(rst_n), .strap_i(strap), .ovr_i(ovr), .code_i(code),
        .prog_en_i(pen), .nm_wr_i(wr), .prog_n_i(pn_in), .prog_m_i(pm_in),
        .wd_en_i(wden), .wd_timeout_i(to), .rcv_sel_i(rsel), .rcv_n_i(rn), .rcv_m_i(rm),
        .strap_o(strap_o), .gear_o(gear_o), .n_o(n_o), .m_o(m_o), .mode_o(mode_o),
        .chg_o(chg_o), .ratio_err_o(err_o)
    );

    // expected {mode, gear, n, m} from the requirements
    function automatic logic [21:0] exp_tuple();
        logic [4:0] g;
        g = ovr ? code : m_lat;
        if (m_rcv)           return {2'd3, m_rgear, m_rn, m_rm};
        else if (pen && m_pv) return {2'd2, g, m_pn, m_pm};
        else if (ovr)         return {2'd1, code, 8'd0, 7'd0};
        else                  return {2'd0, m_lat, 8'd0, 7'd0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_pair(input logic [7:0] n, input logic [6:0] m);
        wr = 1; pn_in = n; pm_in = m;
        if (!m_rcv) begin
            if (n > {1'b0, m}) begin m_pn = n; m_pm = m; m_pv = 1; m_err = 0; end
            else m_err = 1;
        end
    endtask

    task automatic fire_to();
        to = 1;
        if (wden && !m_rcv) begin
            m_rcv = 1;
            if (rsel && rn > {1'b0, rm}) begin
                m_rgear = ovr ? code : m_lat; m_rn = rn; m_rm = rm;
            end else begin
                m_rgear = m_lat; m_rn = 0; m_rm = 0;
            end
        end
    endtask

    task automatic set_wden(input logic b);
        wden = b;
        if (!b) m_rcv = 0;
    endtask

    // after stimulus applied at a negedge: drop pulses, count strobes, compare
    task automatic settle(input string tag, input logic [21:0] old);
        int cnt;
        logic [21:0] nw;
        cnt = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i == 0) begin wr = 0; to = 0; end
            if (chg_o) cnt++;
        end
        nw = exp_tuple();
        check(tag, {10'd0, mode_o, gear_o, n_o, m_o}, {10'd0, nw});
        check(tag, {31'd0, err_o}, {31'd0, m_err});
        check({tag, " R9 strobe count"}, cnt, (nw != old) ? 1 : 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [21:0] old;
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        m_lat = strap;
        rst_n = 1;
        @(negedge clk);
        strap = 5'b00011;   // post-reset strap change must be ignored
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check("R1 strap_o", {27'd0, strap_o}, {27'd0, 5'b10110});
        check("R1 outputs", {10'd0, mode_o, gear_o, n_o, m_o}, {10'd0, 2'd0, 5'b10110, 15'd0});
        check("R1 chg", {31'd0, chg_o}, 32'd0);

        // R2 override selects register code
        @(negedge clk); old = exp_tuple(); code = 5'd9; ovr = 1; settle("R2 ovr on", old);
        @(negedge clk); old = exp_tuple(); ovr = 0; settle("R2 ovr off", old);
        // R4 illegal pair N==M refused
        @(negedge clk); old = exp_tuple(); pen = 1; settle("R2 prog no pair", old);
        @(negedge clk); old = exp_tuple(); wr_pair(8'd5, 7'd5); settle("R4 N==M refused", old);
        // R4 legal boundary N=M+1
        @(negedge clk); old = exp_tuple(); wr_pair(8'd6, 7'd5); settle("R4 N=M+1 taken", old);
        // R9 same pair again, no strobe
        @(negedge clk); old = exp_tuple(); wr_pair(8'd6, 7'd5); settle("R9 repeat write", old);
        // R3 override in programmed mode moves gear
        @(negedge clk); old = exp_tuple(); code = 5'd21; ovr = 1; settle("R3 gear from code", old);
        // R5 write with prog off, then enable
        @(negedge clk); old = exp_tuple(); pen = 0; settle("R5 prog off", old);
        @(negedge clk); old = exp_tuple(); wr_pair(8'd200, 7'd93); settle("R5 write while off", old);
        @(negedge clk); old = exp_tuple(); pen = 1; settle("R5 enable", old);
        // R8 timeout with watchdog disabled ignored
        @(negedge clk); old = exp_tuple(); fire_to(); settle("R8 timeout ignored", old);
        // R6 recovery from pair
        @(negedge clk); old = exp_tuple(); set_wden(1); rsel = 1; rn = 8'd130; rm = 7'd45; settle("R6 arm", old);
        @(negedge clk); old = exp_tuple(); fire_to(); settle("R6 enter recovery", old);
        // R7 lockout
        @(negedge clk); old = exp_tuple(); wr_pair(8'd3, 7'd9); settle("R7 bad write dropped", old);
        @(negedge clk); old = exp_tuple(); wr_pair(8'd99, 7'd1); settle("R7 write dropped", old);
        @(negedge clk); old = exp_tuple(); ovr = 0; code = 5'd2; pen = 0; rn = 8'd7; settle("R7 inputs ignored", old);
        @(negedge clk); old = exp_tuple(); fire_to(); settle("R7 second timeout", old);
        // R8 exit restores normal source
        @(negedge clk); old = exp_tuple(); set_wden(0); settle("R8 exit", old);
        @(negedge clk); old = exp_tuple(); pen = 1; settle("R7 pair kept after lock", old);
        // R6 bad recovery pair falls back to strap
        @(negedge clk); old = exp_tuple(); set_wden(1); rn = 8'd4; rm = 7'd4; settle("R6 arm bad", old);
        @(negedge clk); old = exp_tuple(); fire_to(); settle("R6 bad pair fallback", old);
        @(negedge clk); old = exp_tuple(); set_wden(0); settle("R8 exit again", old);

        // constrained random mix
        for (int s = 0; s < 400; s++) begin
            int a;
            @(negedge clk);
            old = exp_tuple();
            a = $urandom_range(0, 7);
            case (a)
                0: begin ovr = $urandom_range(0, 1); settle("R2 rnd ovr", old); end
                1: begin code = 5'($urandom); settle("R2 rnd code", old); end
                2: begin pen = $urandom_range(0, 1); settle("R3 rnd en", old); end
                3: begin
                    logic [6:0] m;
                    m = 7'($urandom);
                    if ($urandom_range(0, 2) == 0) wr_pair({1'b0, m}, m);
                    else wr_pair(8'($urandom), m);
                    settle("R4 rnd write", old);
                end
                4: begin fire_to(); settle("R6 rnd timeout", old); end
                5: begin set_wden($urandom_range(0, 3) != 0); settle("R8 rnd wden", old); end
                6: begin rsel = $urandom_range(0, 1); rn = 8'($urandom); rm = 7'($urandom); settle("R7 rnd rcv regs", old); end
                default: begin if (m_pv) wr_pair(m_pn, m_pm); else wr_pair(8'd1, 7'd0); settle("R9 rnd rewrite", old); end
            endcase
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule